// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers up to 32 interrupt lines and turns them into two request outputs, one for urgent work and one for routine work. Each line is first brought into the local clock domain. It is then sensed either as a level or as an edge, in whichever sense its polarity bit selects. A detected event sets a sticky pending bit. A per-source enable mask gates the pending bits. A routing mask then sends each gated bit to either the urgent or the routine output.

Software reaches the controller through a small word-wide register port with an address, a write strobe and write data. Reads return data combinationally. A pending bit is cleared by writing a one to its position. Because the bit order is reversed, source n occupies bit 31-n. A priority encoder reports the number of one gated pending source. Controllers can be chained by wiring the routine output of one into an input line of another.

Top module: `intr_ctrl`

## Requirements
- R1: While reset is low, every register (pending, enable, route, polarity, mode, gated) reads zero, and `crit_o`, `noncrit_o` and `vec_valid_o` are low.
- R2: Input `src_i[n]` maps to register bit 31-n for all registers, so source 0 is bit 31 and source 31 is bit 0.
- R3: A write to the pending register (address 0) clears each bit whose written bit is 1. Bits written as 0 keep their value.
- R4: With mode bit 0 (level), a source sets its pending bit on every cycle its synchronised input equals its polarity bit: polarity 1 means high, polarity 0 means low. Clearing it while it is still active leaves it set.
- R5: With mode bit 1 (edge), a pending bit sets on a rising transition when polarity is 1, or on a falling transition when polarity is 0. A transition in the other direction has no effect. The bit stays set after the input returns until software clears it.
- R6: The gated register (address 5) reads as pending AND enable. Writes to it change nothing.
- R7: `crit_o` is the OR of the gated bits whose route bit (address 2) is 1. `noncrit_o` is the OR of the gated bits whose route bit is 0.
- R8: `vec_o` is 31 minus the index of the least significant set gated bit, which is the highest-numbered gated source. `vec_valid_o` is high exactly when the gated register is non-zero.
- R9: When a new event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: An input change applied before clock edge k shows in the pending register after edge k+2, due to a two-flop synchroniser, and not earlier.
- R11: Enable (address 1), route (address 2), polarity (address 3) and mode (address 4) read back the last value written to them. Unused addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt lines, bit n is source n |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| crit_o | output | 1 | Urgent request |
| noncrit_o | output | 1 | Routine request |
| vec_valid_o | output | 1 | A gated source is present |
| vec_o | output | 5 | Number of the reported source |

## Verification
The assertions check four things on every cycle. Each detected event is set in the pending register on the following cycle, even when a clearing write hits the same bit. A pending bit falls only when a one is written to clear it. The reported source number points at the lowest set gated bit with nothing set below it. The two request outputs together agree with the valid flag.

Some behaviour shows only in the bench's scenarios, which run against a cycle-accurate behavioural model:
- the two-cycle synchroniser latency;
- edges of the wrong direction being ignored;
- level sources re-pending after a clear;
- read-only handling of the gated register;
- the reversed bit order.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT  = 3'd0,
    REG_EN    = 3'd1,
    REG_CRIT  = 3'd2,
    REG_POL   = 3'd3,
    REG_TRIG  = 3'd4,
    REG_MSTAT = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/intr_detect.sv
module intr_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] event_o,
  output logic [W-1:0] status_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic prev_q, stat_q, lvl_hit, edge_hit;

    assign lvl_hit  = pol_i[b] ? line_i[b] : ~line_i[b];
    assign edge_hit = pol_i[b] ? (line_i[b] & ~prev_q) : (~line_i[b] & prev_q);
    assign event_o[b] = trig_i[b] ? edge_hit : lvl_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        prev_q <= line_i[b];
        // new event beats a same-cycle clear
        stat_q <= event_o[b] | (stat_q & ~clr_i[b]);
      end
    end

    assign status_o[b] = stat_q;
  end
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int unsigned W     = 32,
  parameter int unsigned VEC_W = $clog2(W)
) (
  input  logic [W-1:0]     masked_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  // scan down so the least significant set bit is assigned last
  always_comb begin
    valid_o = 1'b0;
    vec_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (masked_i[i]) begin
        valid_o = 1'b1;
        vec_o   = VEC_W'(W - 1 - i);
      end
    end
  end
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned VEC_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              crit_o,
  output logic              noncrit_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N_SRC-1:0] src_rev, line_sync;
  logic [N_SRC-1:0] en_q, crit_q, pol_q, trig_q;
  logic [N_SRC-1:0] status_q, event_vec, clr_mask, masked;

  // source n lives in register bit N_SRC-1-n
  for (genvar n = 0; n < N_SRC; n++) begin : g_map
    assign src_rev[N_SRC-1-n] = src_i[n];
  end

  intr_sync #(.W(N_SRC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_rev),
    .q_o    (line_sync)
  );

  assign clr_mask = (we_i && addr_i == REG_STAT) ? wdata_i : '0;

  intr_detect #(.W(N_SRC)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_sync),
    .pol_i    (pol_q),
    .trig_i   (trig_q),
    .clr_i    (clr_mask),
    .event_o  (event_vec),
    .status_o (status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_EN:   en_q   <= wdata_i;
        REG_CRIT: crit_q <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        REG_TRIG: trig_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign masked    = status_q & en_q;
  assign crit_o    = |(masked & crit_q);
  assign noncrit_o = |(masked & ~crit_q);

  intr_prio #(.W(N_SRC), .VEC_W(VEC_W)) u_prio (
    .masked_i (masked),
    .valid_o  (vec_valid_o),
    .vec_o    (vec_o)
  );

  always_comb begin
    case (addr_i)
      REG_STAT:  rdata_o = status_q;
      REG_EN:    rdata_o = en_q;
      REG_CRIT:  rdata_o = crit_q;
      REG_POL:   rdata_o = pol_q;
      REG_TRIG:  rdata_o = trig_q;
      REG_MSTAT: rdata_o = masked;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned VEC_W = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  event_vec,
  input logic [N_SRC-1:0]  masked,
  input logic [N_SRC-1:0]  crit_q,
  input logic              crit_o,
  input logic              noncrit_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o
);
  logic [N_SRC-1:0] wclr, below;

  assign wclr = (we_i && addr_i == REG_STAT) ? wdata_i : '0;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) below[i] = (i < int'(N_SRC - 1) - int'(vec_o));
  end

  // R9: every detected event is pending next cycle
  assert_event_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(event_vec) & ~status_q) == '0));

  // R3: cleared bits drop unless re-hit
  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wclr != '0) |=> ((status_q & $past(wclr) & ~$past(event_vec)) == '0));

  // R5: pending bits only fall by a clearing write
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~$past(wclr) & ~status_q) == '0));

  // R8
  assert_vec_lowest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (masked[N_SRC-1-int'(vec_o)] && ((masked & below) == '0)));

  assert_vec_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (masked == '0));

  // R7
  assert_req_agree_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_o || noncrit_o) == vec_valid_o);

  assert_all_crit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&crit_q) |-> !noncrit_o);
endmodule

bind intr_ctrl intr_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .status_q    (status_q),
  .event_vec   (event_vec),
  .masked      (masked),
  .crit_q      (crit_q),
  .crit_o      (crit_o),
  .noncrit_o   (noncrit_o),
  .vec_valid_o (vec_valid_o),
  .vec_o       (vec_o)
);

// File: tb/intr_ctrl_test.sv
module intr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        crit, noncrit, vvalid;
  logic [4:0]  vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .crit_o(crit), .noncrit_o(noncrit),
    .vec_valid_o(vvalid), .vec_o(vec)
  );

  // behavioural reference, register-bit order
  bit [31:0] m_s1, m_s2, m_prev, m_st, m_en, m_cr, m_pol, m_tr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_st <= 0;
      m_en <= 0; m_cr <= 0; m_pol <= 0; m_tr <= 0;
    end else begin
      bit [31:0] nst;
      for (int b = 0; b < 32; b++) begin
        bit ev, hit_l, hit_e, clr;
        hit_l = m_pol[b] ? m_s2[b] : !m_s2[b];
        hit_e = m_pol[b] ? (m_s2[b] && !m_prev[b]) : (!m_s2[b] && m_prev[b]);
        ev    = m_tr[b] ? hit_e : hit_l;
        clr   = we && addr == 3'd0 && wdata[b];
        nst[b] = ev || (m_st[b] && !clr);
      end
      m_st <= nst;
      if (we) begin
        if (addr == 3'd1) m_en  <= wdata;
        if (addr == 3'd2) m_cr  <= wdata;
        if (addr == 3'd3) m_pol <= wdata;
        if (addr == 3'd4) m_tr  <= wdata;
      end
      m_prev <= m_s2;
      m_s2   <= m_s1;
      for (int n = 0; n < 32; n++) m_s1[31-n] <= src[n];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      bit [31:0] mm, rd;
      bit mv;
      int mvec;
      mm = m_st & m_en;
      mv = 0; mvec = 0;
      for (int b = 31; b >= 0; b--) if (mm[b]) begin mv = 1; mvec = 31 - b; end
      case (addr)
        3'd0: rd = m_st;  3'd1: rd = m_en;  3'd2: rd = m_cr;
        3'd3: rd = m_pol; 3'd4: rd = m_tr;  3'd5: rd = mm;
        default: rd = 0;
      endcase
      check("R11 model rdata", rdata, rd);
      check("R7 model crit", {31'd0, crit}, {31'd0, |(mm & m_cr)});
      check("R7 model noncrit", {31'd0, noncrit}, {31'd0, |(mm & ~m_cr)});
      check("R8 model valid", {31'd0, vvalid}, {31'd0, mv});
      check("R8 model vec", {27'd0, vec}, mv ? 32'(mvec) : 32'd0);
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    cycles(3);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R1 reset register", d, 0);
    end
    check("R1 reset outputs", {29'd0, crit, noncrit, vvalid}, 0);
    @(negedge clk); rst_n = 1;
    cycles(3);
    rd(0, d); check("R4 active-low level pending", d, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R3 clear all", d, 0);
    rd(3, d); check("R11 polarity readback", d, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); check("R11 enable readback", d, 32'hFFFF_FFFF);

    // R10 / R2: source 0 level high
    src[0] = 1'b1;
    rd(0, d); check("R10 no change yet", d, 0);
    @(negedge clk); rd(0, d); check("R10 after one edge", d, 0);
    @(negedge clk); rd(0, d); check("R10 after two edges", d, 0);
    @(negedge clk); rd(0, d); check("R2 R10 source 0 in bit 31", d, 32'h8000_0000);
    check("R8 vec source 0", {27'd0, vec}, 0);
    check("R7 routine request", {31'd0, noncrit}, 1);
    wr(0, 32'h8000_0000);
    rd(0, d); check("R4 level re-pends", d, 32'h8000_0000);
    src[0] = 1'b0; cycles(3);
    wr(0, 32'h8000_0000);
    rd(0, d); check("R4 cleared after release", d, 0);
    check("R8 no valid when empty", {31'd0, vvalid}, 0);

    // R2: source 31
    src[31] = 1'b1; cycles(3);
    rd(0, d); check("R2 source 31 in bit 0", d, 32'h0000_0001);
    check("R8 vec source 31", {27'd0, vec}, 31);
    src[31] = 1'b0; cycles(3);
    wr(0, 32'h0000_0001);

    // R5: edge sources 5 (rising) and 6 (falling)
    wr(4, 32'h0600_0000);
    wr(3, 32'hFDFF_FFFF);
    rd(4, d); check("R11 mode readback", d, 32'h0600_0000);
    src[5] = 1'b1; @(negedge clk); src[5] = 1'b0; cycles(3);
    rd(0, d); check("R5 rising edge sticky", d, 32'h0400_0000);
    check("R8 vec source 5", {27'd0, vec}, 5);
    src[6] = 1'b1; cycles(4);
    rd(0, d); check("R5 wrong-direction edge ignored", d, 32'h0400_0000);
    src[6] = 1'b0; cycles(4);
    rd(0, d); check("R5 falling edge", d, 32'h0600_0000);
    check("R8 higher source wins", {27'd0, vec}, 6);
    wr(0, 32'h0000_0000);
    rd(0, d); check("R3 zero write keeps bits", d, 32'h0600_0000);
    wr(0, 32'h0200_0000);
    rd(0, d); check("R3 partial clear", d, 32'h0400_0000);

    // R6
    wr(1, 32'h0);
    rd(5, d); check("R6 gated with enable off", d, 0);
    check("R6 no request", {30'd0, crit, noncrit}, 0);
    wr(1, 32'h0400_0000);
    rd(5, d); check("R6 gated value", d, 32'h0400_0000);
    wr(5, 32'hFFFF_FFFF);
    rd(5, d); check("R6 gated write ignored", d, 32'h0400_0000);
    rd(1, d); check("R6 enable untouched", d, 32'h0400_0000);
    rd(0, d); check("R6 pending untouched", d, 32'h0400_0000);

    // R7
    wr(2, 32'h0400_0000);
    rd(2, d); check("R11 route readback", d, 32'h0400_0000);
    check("R7 urgent routing", {30'd0, crit, noncrit}, 32'd2);
    wr(2, 32'h0);
    check("R7 routine routing", {30'd0, crit, noncrit}, 32'd1);
    rd(7, d); check("R11 unused address", d, 0);

    // R9: edge event coincides with clear
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R9 precondition", d, 0);
    src[5] = 1'b1;
    @(negedge clk); src[5] = 1'b0;
    @(negedge clk); we = 1; addr = 3'd0; wdata = 32'h0400_0000;
    @(negedge clk); we = 0;
    rd(0, d); check("R9 event beats clear", d, 32'h0400_0000);

    cycles(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule